// File: doc/BRIEF.md
# Reset Cause and Soft Reset Register

This block is a single 32-bit memory-mapped register that remembers why the system last came out of reset and lets software ask for a new reset. Five bits carry meaning. One cause bit is set by the power-on reset. Two cause bits are set by strobes from the front-panel reset buttons. Software clears these three bits by writing ones to them. The other two bits are soft-reset request bits. Software sets them by writing ones, and writing never clears them. Every other bit reads as zero.

The block has two reset inputs. The power-on reset `por_n` is the cold reset. It loads the register with only the power-on cause bit set. The warm reset `sys_rst_n` leaves the register as it is, so the recorded cause survives every later reset until software clears it. A write that sets a soft-reset bit also raises a one-cycle request pulse toward the system reset sequencer. A side output on that pulse tells the sequencer which kind of reset was asked for.

Register access uses plain control pins: a write strobe, an address, write data, and read data decoded combinationally from the address. There is no flow control.

Top module: `rst_cause_reg`

## Requirements
- R1: After `por_n` is released, a read of the register returns 0x80000000: bit 31, the power-on cause, is set and every other bit is zero.
- R2: A warm reset (`sys_rst_n` low) leaves the register value unchanged and holds `rst_req` low.
- R3: Bits 31, 28 and 27 are write-one-to-clear. Writing a one clears the bit, and writing a zero leaves it unchanged.
- R4: Bits 30 (soft power-on) and 29 (soft external) are set by writing a one. Writing a zero never clears them; only `por_n` clears them.
- R5: Bits 26 to 0 always read as zero, whatever value is written.
- R6: A write with bit 30 set drives `rst_req` high for exactly one cycle, in the cycle after the write edge, with `rst_req_por` high.
- R7: A write with bit 29 set and bit 30 clear pulses `rst_req` with `rst_req_por` low. When both bits are set, bit 30 wins and `rst_req_por` is high.
- R8: A one-cycle strobe on `btn_por` sets bit 28, and one on `btn_xir` sets bit 27. If a strobe arrives in the same cycle as a clearing write, the set wins.
- R9: The register answers only to byte addresses 0xF020 to 0xF027. Writes to other addresses change nothing and raise no request, and reads from other addresses return zero.
- R10: A write that has neither bit 30 nor bit 29 set raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on (cold) reset, active low, asynchronous |
| sys_rst_n | input | 1 | Warm system reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe |
| addr | input | 16 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| btn_por | input | 1 | Power-on button strobe |
| btn_xir | input | 1 | External-reset button strobe |
| rst_req | output | 1 | One-cycle system reset request |
| rst_req_por | output | 1 | Kind of request on `rst_req`: 1 = power-on, 0 = external |

## Verification
Because the register is read combinationally, a wrong stored bit shows on `rdata` half a cycle after the edge that stored it. The bench reads the register back after every write, strobe and reset. A wrong request decision shows on `rst_req` and `rst_req_por` in the cycle right after the write. The bench also checks the following cycle, so a pulse that lasts too long or is missing is caught within two cycles. Loss of state across a warm reset shows on the first read after that reset is released.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 16;
  // bit positions of the live fields (software decodes these)
  localparam int B_POR      = 31;
  localparam int B_SOFT_POR = 30;
  localparam int B_SOFT_XIR = 29;
  localparam int B_BTN_POR  = 28;
  localparam int B_BTN_XIR  = 27;
  localparam int LIVE_LSB   = B_BTN_XIR;
  localparam int LIVE_W     = REG_W - LIVE_LSB;
  typedef logic [LIVE_W-1:0] live_t;
  // indices inside live_t
  localparam int I_POR      = B_POR - LIVE_LSB;
  localparam int I_SOFT_POR = B_SOFT_POR - LIVE_LSB;
  localparam int I_SOFT_XIR = B_SOFT_XIR - LIVE_LSB;
  localparam int I_BTN_POR  = B_BTN_POR - LIVE_LSB;
  localparam int I_BTN_XIR  = B_BTN_XIR - LIVE_LSB;
endpackage

// File: rtl/rst_cause_decode.sv
module rst_cause_decode
  import rst_cause_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE   = 16'hF020,
  parameter int                SPAN_B = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  live_t             live,
  output logic              hit,
  output logic              wr_hit,
  output logic [REG_W-1:0]  rdata
);
  localparam int TAG_W = ADDR_W - SPAN_B;

  assign hit    = (addr[ADDR_W-1:SPAN_B] == BASE[ADDR_W-1:SPAN_B]);
  assign wr_hit = hit & wr_en;

  for (genvar b = 0; b < REG_W; b++) begin : g_rd
    if (b >= LIVE_LSB) begin : g_live
      assign rdata[b] = hit & live[b-LIVE_LSB];
    end else begin : g_zero
      assign rdata[b] = 1'b0;
    end
  end

  always_comb begin
    assert (hit || (rdata == '0)) else $error("p_miss_reads_zero_r9");
    assert (rdata[LIVE_LSB-1:0] == '0) else $error("p_unused_zero_r5");
  end

  logic unused_tag;
  assign unused_tag = ^TAG_W;
endmodule

// File: rtl/rst_cause_bits.sv
module rst_cause_bits
  import rst_cause_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic             btn_por,
  input  logic             btn_xir,
  output live_t            live
);
  live_t q, d;

  always_comb begin
    d = q;
    if (wr_hit) begin
      d[I_POR]      = q[I_POR]     & ~wdata[B_POR];
      d[I_BTN_POR]  = q[I_BTN_POR] & ~wdata[B_BTN_POR];
      d[I_BTN_XIR]  = q[I_BTN_XIR] & ~wdata[B_BTN_XIR];
      d[I_SOFT_POR] = q[I_SOFT_POR] | wdata[B_SOFT_POR];
      d[I_SOFT_XIR] = q[I_SOFT_XIR] | wdata[B_SOFT_XIR];
    end
    if (btn_por) d[I_BTN_POR] = 1'b1;
    if (btn_xir) d[I_BTN_XIR] = 1'b1;
  end

  // only the cold reset touches this state; warm resets leave it alone
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      q        <= '0;
      q[I_POR] <= 1'b1;
    end else begin
      q <= d;
    end
  end

  assign live = q;

  p_soft_sticky_r4: assert property (@(posedge clk) disable iff (!por_n)
    q[I_SOFT_POR] |=> q[I_SOFT_POR]);
  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!por_n)
    (wr_hit && wdata[B_POR]) |=> !q[I_POR]);
  p_btn_sets_r8: assert property (@(posedge clk) disable iff (!por_n)
    btn_xir |=> q[I_BTN_XIR]);
endmodule

// File: rtl/rst_cause_req.sv
module rst_cause_req
  import rst_cause_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  output logic             req,
  output logic             req_por
);
  logic want_por, want_xir;
  assign want_por = wr_hit & wdata[B_SOFT_POR];
  assign want_xir = wr_hit & wdata[B_SOFT_XIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req     <= 1'b0;
      req_por <= 1'b0;
    end else begin
      req     <= want_por | want_xir;
      req_por <= want_por;
    end
  end

  p_por_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
    want_por |=> (req && req_por));
  p_req_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(wr_hit && (wdata[B_SOFT_POR] || wdata[B_SOFT_XIR])));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              btn_por,
  input  logic              btn_xir,
  output logic              rst_req,
  output logic              rst_req_por
);
  live_t live;
  logic  hit, wr_hit, req_rst_n;

  assign req_rst_n = por_n & sys_rst_n;

  rst_cause_decode u_dec (
    .addr(addr), .wr_en(wr_en), .live(live),
    .hit(hit), .wr_hit(wr_hit), .rdata(rdata)
  );

  rst_cause_bits u_bits (
    .clk(clk), .por_n(por_n), .wr_hit(wr_hit), .wdata(wdata),
    .btn_por(btn_por), .btn_xir(btn_xir), .live(live)
  );

  rst_cause_req u_req (
    .clk(clk), .rst_n(req_rst_n), .wr_hit(wr_hit), .wdata(wdata),
    .req(rst_req), .req_por(rst_req_por)
  );

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!req_rst_n)
    (rst_req && !$past(wr_hit)) |-> 1'b0);
  p_miss_no_req_r9: assert property (@(posedge clk) disable iff (!req_rst_n)
    (wr_en && !hit) |=> !rst_req);
endmodule

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;
  logic        clk = 0;
  logic        por_n = 0, sys_rst_n = 0, wr_en = 0;
  logic [15:0] addr = 16'hF020;
  logic [31:0] wdata = 0, rdata;
  logic        btn_por = 0, btn_xir = 0, rst_req, rst_req_por;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rst_cause_reg u_rst_cause_reg (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .btn_por(btn_por),
    .btn_xir(btn_xir), .rst_req(rst_req), .rst_req_por(rst_req_por)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic [15:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #0.5;
    chk(tag, rdata, exp);
    addr = 16'hF020;
  endtask

  // write; on return we sit at the negedge after the capturing edge
  task automatic wr(logic [15:0] a, logic [31:0] d, bit btn_x = 0);
    @(negedge clk); addr = a; wdata = d; wr_en = 1; btn_xir = btn_x;
    @(negedge clk); wr_en = 0; wdata = 0; btn_xir = 0; addr = 16'hF020;
  endtask

  task automatic req_chk(string tag, logic exp_req, logic exp_por);
    chk(tag, {30'd0, rst_req, rst_req_por}, {30'd0, exp_req, exp_req & exp_por});
    @(negedge clk);
    chk({tag, " next cycle low"}, {31'd0, rst_req}, 32'd0);
  endtask

  task automatic t_por();
    por_n = 0; sys_rst_n = 0;
    repeat (3) @(negedge clk);
    por_n = 1; sys_rst_n = 1;
    rd("R1 power-on value", 16'hF020, 32'h8000_0000);
    chk("R1 no request after reset", {31'd0, rst_req}, 0);
  endtask

  task automatic t_unused();
    wr(16'hF020, 32'h07FF_FFFF);
    req_chk("R10 no request for unused bits", 0, 0);
    rd("R5 unused bits read zero", 16'hF020, 32'h8000_0000);
  endtask

  task automatic t_w1c();
    wr(16'hF020, 32'h0);
    rd("R3 zero write keeps bit 31", 16'hF020, 32'h8000_0000);
    wr(16'hF020, 32'h8000_0000);
    rd("R3 one clears bit 31", 16'hF020, 32'h0);
  endtask

  task automatic t_buttons();
    @(negedge clk); btn_por = 1; @(negedge clk); btn_por = 0;
    @(negedge clk); btn_xir = 1; @(negedge clk); btn_xir = 0;
    rd("R8 button strobes set 28 and 27", 16'hF020, 32'h1800_0000);
    wr(16'hF020, 32'h1000_0000);
    rd("R3 clear bit 28 only", 16'hF020, 32'h0800_0000);
    wr(16'hF020, 32'h0800_0000, 1);
    rd("R8 strobe beats same-cycle clear", 16'hF020, 32'h0800_0000);
    wr(16'hF020, 32'h0800_0000);
    rd("R3 clear bit 27", 16'hF020, 32'h0);
  endtask

  task automatic t_soft();
    wr(16'hF020, 32'h2000_0000);
    req_chk("R7 external request", 1, 0);
    rd("R4 bit 29 set", 16'hF020, 32'h2000_0000);
    wr(16'hF020, 32'h0);
    req_chk("R10 zero write no request", 0, 0);
    rd("R4 zero write keeps bit 29", 16'hF020, 32'h2000_0000);
    wr(16'hF020, 32'h6000_0000);
    req_chk("R7 bit 30 has priority", 1, 1);
    wr(16'hF020, 32'h4000_0000);
    req_chk("R6 power-on request one cycle", 1, 1);
    rd("R4 both soft bits set", 16'hF020, 32'h6000_0000);
  endtask

  task automatic t_window();
    wr(16'hF028, 32'hFFFF_FFFF);
    req_chk("R9 miss write no request", 0, 0);
    rd("R9 miss read zero", 16'hF028, 32'h0);
    rd("R9 in-window alias read", 16'hF024, 32'h6000_0000);
    rd("R9 miss write no change", 16'hF020, 32'h6000_0000);
  endtask

  task automatic t_warm();
    @(negedge clk); sys_rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R2 request low during warm reset", {31'd0, rst_req}, 0);
    sys_rst_n = 1;
    rd("R2 value survives warm reset", 16'hF020, 32'h6000_0000);
  endtask

  initial begin
    fork
      begin
        t_por(); t_unused(); t_w1c(); t_buttons();
        t_soft(); t_window(); t_warm(); t_por();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule